// File: doc/BRIEF.md
# Nested Exception Escalation Unit

This unit sits between the sources that report processor exceptions and the logic that delivers them to a handler. Each report gives a vector number, a caller-supplied error code and a flag that says whether the stack pointer can be backed out. The unit sorts the vector into one of four severity classes. It then decides one of three outcomes: deliver the exception as reported, promote it to a double fault, or declare a shutdown because a triple fault has occurred.

For each delivery the unit states four things:
- the vector that is finally delivered;
- whether an error code is pushed;
- the value of that error code;
- whether the saved instruction pointer, and possibly the stack pointer, roll back to the faulting instruction.

A saturating nesting counter and the last delivered vector are kept from one report to the next. The downstream delivery logic pulses a completion input once a handler has been entered successfully, and that pulse clears the counter. A vector with no defined meaning raises an internal-error pulse and is not delivered.

Top module: `exc_escalate`

## Requirements
- R1: Vectors map to severity classes as follows. Class 1 (contributory) holds vectors 0, 10, 11, 12 and 13. Class 2 (page fault) holds vector 14. Class 3 (double fault) holds vector 8. Every other defined vector is class 0 (benign). The defined vectors are 0 to 14 and 16 to 19.
- R2: A report is promoted to a delivery of vector 8 when two conditions hold: the nesting count after the report is at least 2, and the pair (class of the previous delivered vector, class of the new vector) is set. A pair is set when either class is 3, when both classes are 1, or when the previous class is 2 and the new class is 1 or 2.
- R3: Each report raises the nesting count by one, saturating at 3. When the count after the report reaches 3, the outcome is a shutdown pulse instead of a delivery.
- R4: When the count after a report is exactly 2 and the previous delivered vector is 8, the outcome is a shutdown pulse.
- R5: A delivery of vector 8, whether reported directly or promoted, pushes an error code of value zero.
- R6: Vectors 10 to 14 push the error code that came with the report. Vector 17 pushes an error code of zero. All other vectors push no code. Whenever no code is pushed, the code output is zero.
- R7: The instruction-pointer rollback output is set when the reported vector is one of 0, 1, 5, 6, 7, 10 to 14, 16 or 17. This is decided from the reported vector even when the report is promoted. The stack-pointer rollback output is set only when the instruction pointer rolls back and the backout flag was set with the report.
- R8: The previous-vector state is updated only by a delivery, and it takes the vector finally delivered, after any promotion. After reset it holds 0.
- R9: A report of vector 15 or of any vector above 19 produces an internal-error pulse and no delivery. Shutdown takes priority over this check.
- R10: Each report produces exactly one of three one-cycle output pulses: delivery, shutdown or internal error. The pulse appears on the clock edge that samples the report. No pulse appears in a cycle without a report, and all pulses are low after reset.
- R11: A completion pulse clears the nesting count. When a completion pulse and a report arrive in the same cycle, the count is cleared first and the report then counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | An exception is reported this cycle |
| rpt_vector | input | VEC_W | Reported vector number |
| rpt_code | input | CODE_W | Caller-supplied error code |
| rpt_sp_backout | input | 1 | Stack pointer may be restored for this report |
| dlv_done | input | 1 | Downstream delivery completed; clears nesting count |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_vector | output | VEC_W | Vector delivered |
| dlv_push_code | output | 1 | An error code is pushed |
| dlv_code | output | CODE_W | Error code value pushed |
| dlv_rewind_ip | output | 1 | Instruction pointer rolls back to the faulting instruction |
| dlv_rewind_sp | output | 1 | Stack pointer is restored |
| shutdown | output | 1 | Triple-fault shutdown pulse |
| bad_vector | output | 1 | Internal-error pulse for an undefined vector |

## Verification
The hardest states to reach from the ports are the two shutdown conditions and the promotion of the second of two nested reports. Reaching them needs several reports in a row with no completion pulse between them, and the previous delivery has to be of the right class. Random stimulus therefore keeps completion pulses rare. Directed sequences add the cases random stimulus is unlikely to produce:
- a page fault followed by a contributory fault, which is promoted;
- a contributory fault followed by a page fault, which is not promoted;
- a direct double fault followed by any report, which shuts down at count 2;
- a completion pulse and a report in the same cycle.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

  typedef enum logic [1:0] {
    CLS_BENIGN  = 2'd0,
    CLS_CONTRIB = 2'd1,
    CLS_PAGE    = 2'd2,
    CLS_DOUBLE  = 2'd3
  } exc_class_e;

  localparam int unsigned VEC_DOUBLE = 8;
  localparam int unsigned VEC_ALIGN  = 17;
  localparam int unsigned VEC_HOLE   = 15;
  localparam int unsigned VEC_LAST   = 19;
  localparam int unsigned NUM_CLASS  = 4;

  // Escalation rule for (previous class, new class).
  function automatic logic esc_pair(input int unsigned prev_c, input int unsigned new_c);
    return (prev_c == 3) || (new_c == 3) ||
           (prev_c == 1 && new_c == 1) ||
           (prev_c == 2 && (new_c == 1 || new_c == 2));
  endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_esc_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input  logic [VEC_W-1:0] vec,
  output exc_class_e       cls,
  output logic             known,
  output logic             has_code,
  output logic             zero_code,
  output logic             is_fault
);
  always_comb begin
    cls       = CLS_BENIGN;
    known     = (int'(vec) <= VEC_LAST) && (int'(vec) != VEC_HOLE);
    has_code  = 1'b0;
    zero_code = 1'b0;
    is_fault  = 1'b0;
    case (int'(vec))
      0:              begin cls = CLS_CONTRIB; is_fault = 1'b1; end
      1, 5, 6, 7, 16: is_fault = 1'b1;
      8:              begin cls = CLS_DOUBLE; has_code = 1'b1; zero_code = 1'b1; end
      10, 11, 12, 13: begin cls = CLS_CONTRIB; has_code = 1'b1; is_fault = 1'b1; end
      14:             begin cls = CLS_PAGE; has_code = 1'b1; is_fault = 1'b1; end
      17:             begin has_code = 1'b1; zero_code = 1'b1; is_fault = 1'b1; end
      default:        ;
    endcase
  end
endmodule

// File: rtl/exc_esc_matrix.sv
module exc_esc_matrix
  import exc_esc_pkg::*;
(
  input  exc_class_e prev_cls,
  input  exc_class_e new_cls,
  output logic       hit
);
  localparam int unsigned ENTRIES = NUM_CLASS * NUM_CLASS;
  logic [ENTRIES-1:0] table_bits;

  for (genvar p = 0; p < NUM_CLASS; p++) begin : g_prev
    for (genvar n = 0; n < NUM_CLASS; n++) begin : g_new
      assign table_bits[p*NUM_CLASS+n] = esc_pair(p, n);
    end
  end

  assign hit = table_bits[{prev_cls, new_cls}];
endmodule

// File: rtl/exc_nest_counter.sv
module exc_nest_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  input  logic             clear,
  output logic [CNT_W-1:0] count_nx
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] base;

  assign base     = clear ? '0 : count_q;
  assign count_nx = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (bump)  count_q <= count_nx;
    else if (clear) count_q <= '0;
  end

  // R11: a completion pulse without a report leaves the count at zero
  a_r11_clear_count: assert property (@(posedge clk) disable iff (rst)
    (clear && !bump) |=> (count_q == '0));
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_esc_pkg::*;
#(
  parameter int unsigned VEC_W  = 5,
  parameter int unsigned CODE_W = 32,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_valid,
  input  logic [VEC_W-1:0]  rpt_vector,
  input  logic [CODE_W-1:0] rpt_code,
  input  logic              rpt_sp_backout,
  input  logic              dlv_done,
  output logic              dlv_valid,
  output logic [VEC_W-1:0]  dlv_vector,
  output logic              dlv_push_code,
  output logic [CODE_W-1:0] dlv_code,
  output logic              dlv_rewind_ip,
  output logic              dlv_rewind_sp,
  output logic              shutdown,
  output logic              bad_vector
);
  localparam logic [CNT_W-1:0] LVL_NEST   = CNT_W'(2);
  localparam logic [CNT_W-1:0] LVL_TRIPLE = CNT_W'(3);
  localparam logic [VEC_W-1:0] DF_VEC     = VEC_W'(VEC_DOUBLE);

  exc_class_e       new_cls, prev_cls;
  logic             new_known, new_has, new_zero, new_fault;
  logic             prev_known, prev_has, prev_zero, prev_fault;
  logic             pair_hit;
  logic [CNT_W-1:0] cnt_nx;
  logic [VEC_W-1:0] prev_vec_q;
  logic             go_shut, go_bad, go_promote;

  exc_classify #(.VEC_W(VEC_W)) u_cls_new (
    .vec(rpt_vector), .cls(new_cls), .known(new_known),
    .has_code(new_has), .zero_code(new_zero), .is_fault(new_fault));

  exc_classify #(.VEC_W(VEC_W)) u_cls_prev (
    .vec(prev_vec_q), .cls(prev_cls), .known(prev_known),
    .has_code(prev_has), .zero_code(prev_zero), .is_fault(prev_fault));

  exc_esc_matrix u_matrix (.prev_cls(prev_cls), .new_cls(new_cls), .hit(pair_hit));

  exc_nest_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .bump(rpt_valid), .clear(dlv_done), .count_nx(cnt_nx));

  assign go_shut    = (cnt_nx >= LVL_TRIPLE) ||
                      (cnt_nx == LVL_NEST && prev_vec_q == DF_VEC);
  assign go_bad     = !go_shut && !new_known;
  assign go_promote = (cnt_nx >= LVL_NEST) && pair_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid     <= 1'b0;
      dlv_vector    <= '0;
      dlv_push_code <= 1'b0;
      dlv_code      <= '0;
      dlv_rewind_ip <= 1'b0;
      dlv_rewind_sp <= 1'b0;
      shutdown      <= 1'b0;
      bad_vector    <= 1'b0;
      prev_vec_q    <= '0;
    end else begin
      dlv_valid  <= rpt_valid && !go_shut && !go_bad;
      shutdown   <= rpt_valid && go_shut;
      bad_vector <= rpt_valid && go_bad;
      if (rpt_valid && !go_shut && !go_bad) begin
        dlv_rewind_ip <= new_fault;
        dlv_rewind_sp <= new_fault && rpt_sp_backout;
        if (go_promote) begin
          dlv_vector    <= DF_VEC;
          dlv_push_code <= 1'b1;
          dlv_code      <= '0;
          prev_vec_q    <= DF_VEC;
        end else begin
          dlv_vector    <= rpt_vector;
          dlv_push_code <= new_has;
          dlv_code      <= (new_has && !new_zero) ? rpt_code : '0;
          prev_vec_q    <= rpt_vector;
        end
      end
    end
  end

  // R10: at most one outcome per cycle
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dlv_valid, shutdown, bad_vector}));
  // R10: any outcome follows a report
  a_r10_needs_report: assert property (@(posedge clk) disable iff (rst)
    !rpt_valid |=> !(dlv_valid || shutdown || bad_vector));
  // R5: double-fault delivery pushes a zero code
  a_r5_df_zero_code: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_vector == DF_VEC) |-> (dlv_push_code && dlv_code == '0));
  // R6: no push means zero code
  a_r6_quiet_code: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_push_code) |-> (dlv_code == '0));
  // R7: stack rollback implies instruction rollback
  a_r7_sp_implies_ip: assert property (@(posedge clk) disable iff (rst)
    dlv_rewind_sp |-> dlv_rewind_ip);
  // R8: a delivery leaves its vector as the previous vector
  a_r8_prev_tracks: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (prev_vec_q == dlv_vector));
endmodule

// File: tb/exc_escalate_tb.sv
module exc_escalate_tb;
  localparam int VW = 5;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          rpt_valid, rpt_sp_backout, dlv_done;
  logic [VW-1:0] rpt_vector;
  logic [CW-1:0] rpt_code;
  logic          dlv_valid, dlv_push_code, dlv_rewind_ip, dlv_rewind_sp;
  logic          shutdown, bad_vector;
  logic [VW-1:0] dlv_vector;
  logic [CW-1:0] dlv_code;

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;
  int m_prev = 0;

  always #5 clk = ~clk;

  exc_escalate u_dut (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_vector(rpt_vector),
    .rpt_code(rpt_code), .rpt_sp_backout(rpt_sp_backout), .dlv_done(dlv_done),
    .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_push_code(dlv_push_code),
    .dlv_code(dlv_code), .dlv_rewind_ip(dlv_rewind_ip), .dlv_rewind_sp(dlv_rewind_sp),
    .shutdown(shutdown), .bad_vector(bad_vector));

  function automatic int cls_of(int v);
    if (v == 0 || (v >= 10 && v <= 13)) return 1;
    if (v == 14) return 2;
    if (v == 8) return 3;
    return 0;
  endfunction

  function automatic bit pair_set(int p, int n);
    return p == 3 || n == 3 || (p == 1 && n == 1) || (p == 2 && (n == 1 || n == 2));
  endfunction

  function automatic bit fault_of(int v);
    return v inside {0, 1, 5, 6, 7, 10, 11, 12, 13, 14, 16, 17};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model, then check after the edge.
  task automatic step(bit v, int vec, logic [CW-1:0] code, bit bk, bit done);
    int  nx, fv;
    bit  sh, bad, dl, push, prom;
    logic [CW-1:0] ecode;
    rpt_valid = v; rpt_vector = VW'(vec); rpt_code = code;
    rpt_sp_backout = bk; dlv_done = done;
    nx = done ? 0 : m_cnt;
    nx = (nx >= 3) ? 3 : nx + 1;
    sh = v && (nx >= 3 || (nx == 2 && m_prev == 8));
    bad = v && !sh && (vec == 15 || vec > 19);
    dl = v && !sh && !bad;
    prom = (nx >= 2) && pair_set(cls_of(m_prev), cls_of(vec));
    fv = prom ? 8 : vec;
    push = prom || vec == 8 || vec == 17 || (vec >= 10 && vec <= 14);
    ecode = (!prom && vec >= 10 && vec <= 14) ? code : '0;
    if (v) m_cnt = nx; else if (done) m_cnt = 0;
    if (dl) m_prev = fv;
    @(posedge clk);
    @(negedge clk);
    chk(sh ? "R3/R4 shutdown" : "R3 shutdown", shutdown, sh);
    chk("R9 bad_vector", bad_vector, bad);
    chk(done && v ? "R11 dlv_valid" : "R10 dlv_valid", dlv_valid, dl);
    if (dl) begin
      chk(prom ? "R2 vector" : "R1 vector", dlv_vector, fv);
      chk(prom ? "R5 push" : "R6 push", dlv_push_code, push);
      chk(prom ? "R5 code" : "R6 code", dlv_code, ecode);
      chk("R7 rewind_ip", dlv_rewind_ip, fault_of(vec));
      chk("R7 rewind_sp", dlv_rewind_sp, fault_of(vec) && bk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    rst = 1'b1; rpt_valid = 0; rpt_vector = 0; rpt_code = 0;
    rpt_sp_backout = 0; dlv_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset valid", dlv_valid, 0);
    chk("R10 reset shutdown", shutdown, 0);
    chk("R10 reset bad", bad_vector, 0);
    rst = 1'b0;

    // R2: page fault then contributory -> promoted
    step(1, 14, 32'hAAAA5555, 1, 0);
    step(1, 13, 32'h1234, 0, 0);
    // R3: third report shuts down
    step(1, 3, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    // R2: contributory then page fault -> not promoted
    step(1, 13, 32'h77, 1, 0);
    step(1, 14, 32'h99, 1, 0);
    step(0, 0, 0, 0, 1);
    // R4: direct double fault then any report -> shutdown at count 2
    step(1, 8, 32'hFFFF, 1, 0);
    step(1, 3, 0, 0, 0);
    // R11: completion and report in same cycle
    step(1, 2, 0, 0, 1);
    step(1, 17, 32'hDEAD, 1, 1);
    // R9: undefined vectors
    step(1, 15, 0, 0, 1);
    step(1, 25, 0, 0, 1);
    // R8: benign delivery as previous, then contributory -> no promotion
    step(1, 4, 0, 0, 1);
    step(1, 12, 32'h42, 1, 0);
    step(0, 0, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      int  r, vec;
      bit  v, done;
      r    = int'($urandom % 100);
      v    = r < 80;
      done = ($urandom % 100) < 20;
      vec  = (($urandom % 10) == 0) ? int'($urandom % 32) : int'($urandom % 20);
      step(v, vec, $urandom, bit'($urandom % 2), done);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule